// File: doc/BRIEF.md
# Match-compare system timer

This block is a small memory-mapped system timer. It contains a free-running up-counter that advances once for every cycle in which the tick-enable input is high. It also holds one compare value, an interrupt-enable word and a single sticky status flag. The intended tick rate is a nominal 50 MHz. Tick generation lives outside the block and arrives on `tick_en`.

The flag is set when the counter steps onto the compare value, but only while the enable word is non-zero. The interrupt output is a level signal that follows the flag. Software acknowledges the interrupt by writing zero to the status offset.

A compare value that is at or behind the current count is reached only after the counter wraps. Software therefore programs the next deadline as "now plus delta" and does not need to handle the wrap itself.

The register port is a plain word bus: address, write strobe, write data and combinational read data. Only full 32-bit words are accessed.

Top module: `ost_timer`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the counter, compare value, enable word and status flag are all zero and `irq` is low.
- R2: The counter rises by exactly one at each clock edge where `tick_en` is high and holds otherwise. It wraps from 2^CNT_W-1 to 0 (CNT_W defaults to 32).
- R3: A hit occurs at the edge where the counter advances onto the compare value. If the enable word is non-zero at that edge, the status flag becomes 1 and `irq` goes high in the same cycle that the counter first reads back the compare value.
- R4: A hit that happens while the enable word is zero leaves the flag at 0 and `irq` low.
- R5: When the compare value is less than or equal to the counter at the time it is written, the next hit comes only after the counter wraps. The hit comes after exactly (compare - count) mod 2^CNT_W ticks, or after 2^CNT_W ticks when the two are equal.
- R6: A write of zero to offset 0x14 clears a set flag, and `irq` is low from the next cycle on.
- R7: A write of any non-zero value to offset 0x14 leaves the flag unchanged.
- R8: When a hit with the enable word non-zero and a zero-write to offset 0x14 fall on the same edge, the flag ends up set.
- R9: Reads return the counter at 0x10, the flag in bit 0 of 0x14 (other bits zero), and the enable word at 0x1C. Reads of the compare offset 0x00 and of every other address return zero.
- R10: Writes go to 0x00 (compare value) and 0x1C (enable word). Writes to 0x10 and to every unmapped address change no state.
- R11: `irq` equals the status flag at all times. Once set, it stays high until it is cleared as in R6, even if the enable word is zeroed in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance strobe, one count per high cycle |
| bus_addr | input | ADDR_W (8) | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt, high while the status flag is set |

## Verification
A wrong counter shows at offset 0x10 in the very next cycle. It also shows later as an interrupt that rises at the wrong count, or that rises too early or too late relative to the programmed distance to the compare value. A wrong flag appears on `irq` and in bit 0 of offset 0x14 in the cycle after the faulty edge. A compare value that was latched wrongly cannot be read back, so it shows only when the interrupt fails to rise at the counter value it should. The wrap path is exercised with a narrow counter, so that both the behind-the-count and equal-to-count deadlines are reached within a short run.

// File: rtl/ost_pkg.sv
// Shared constants and types for the match-compare system timer.
// Assumes word-aligned byte addresses of at least 5 bits.
package ost_pkg;

    // Register offsets (byte addresses of 32-bit words)
    localparam logic [7:0] OFS_MATCH  = 8'h00;
    localparam logic [7:0] OFS_COUNT  = 8'h10;
    localparam logic [7:0] OFS_STATUS = 8'h14;
    localparam logic [7:0] OFS_IRQEN  = 8'h1C;

    // Decoded write strobes handed from the bus decoder to the state logic
    typedef struct packed {
        logic match_we;   // store a new compare value
        logic irqen_we;   // store a new interrupt-enable word
        logic status_we;  // write to the status offset (value judged downstream)
    } ost_wstb_t;

endpackage

// File: rtl/ost_free_counter.sv
// Free-running up-counter of the timer.
// Advances by one on every cycle with tick_en high and wraps modulo 2^CNT_W.
// Exports both the current value and the value it will hold after this edge,
// so that the compare logic can detect the step onto the compare value.
// Assumes: synchronous active-low reset.
module ost_free_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);

    // Next-state value: one step forward while ticking
    always_comb begin
        cnt_nxt = tick_en ? cnt_q + 1'b1 : cnt_q;
    end

    // Count register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> cnt_q == $past(cnt_q) + 1'b1);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));

endmodule

// File: rtl/ost_bus_decode.sv
// Register-bus decoder for the timer.
// Turns a write on the word bus into per-register strobes and selects the
// read data combinationally from the current address.
// Assumes: full-word accesses only; any address that does not exactly match
// a mapped offset (including misaligned ones) is treated as unmapped.
module ost_bus_decode
    import ost_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] count_val,
    input  logic              flag_val,
    input  logic [DATA_W-1:0] irqen_val,
    output ost_wstb_t         wstb,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_MATCH  = ADDR_W'(OFS_MATCH);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_IRQEN  = ADDR_W'(OFS_IRQEN);

    // Write strobes: only the compare, status and enable offsets are writable
    always_comb begin
        wstb.match_we  = bus_we && (bus_addr == A_MATCH);
        wstb.irqen_we  = bus_we && (bus_addr == A_IRQEN);
        wstb.status_we = bus_we && (bus_addr == A_STATUS);
    end

    // Read mux: the compare value and unmapped addresses read as zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_COUNT)       bus_rdata = count_val;
        else if (bus_addr == A_STATUS) bus_rdata = {{(DATA_W-1){1'b0}}, flag_val};
        else if (bus_addr == A_IRQEN)  bus_rdata = irqen_val;
    end

    // R10
    one_strobe_chk: assert final ($countones(wstb) <= 1);

endmodule

// File: rtl/ost_match_unit.sv
// Compare and status logic of the timer.
// Holds the compare value, the interrupt-enable word and the sticky flag.
// A hit is the step of the counter onto the compare value. The flag is set
// on a hit while enabled, and cleared by a zero-write to the status offset.
// A hit wins over a same-edge clear.
// Assumes: cnt_nxt is the counter value after the current edge.
module ost_match_unit
    import ost_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [CNT_W-1:0]  cnt_nxt,
    input  ost_wstb_t         wstb,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]  match_q,
    output logic [DATA_W-1:0] irqen_q,
    output logic              flag_q
);

    logic hit;
    logic arm;
    logic clr;

    // Event decode: hit on stepping onto compare, clear on a zero status write
    always_comb begin
        hit = tick_en && (cnt_nxt == match_q);
        arm = hit && (|irqen_q);
        clr = wstb.status_we && (bus_wdata == '0);
    end

    // Compare value register: low CNT_W bits of the written word
    always_ff @(posedge clk) begin
        if (!rst_n)             match_q <= '0;
        else if (wstb.match_we) match_q <= bus_wdata[CNT_W-1:0];
    end

    // Interrupt-enable word, kept in full so it reads back unchanged
    always_ff @(posedge clk) begin
        if (!rst_n)             irqen_q <= '0;
        else if (wstb.irqen_we) irqen_q <= bus_wdata;
    end

    // Sticky status flag: set by an enabled hit, which wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (arm) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    // R3 / R8
    enabled_hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_nxt == match_q && irqen_q != '0) |=> flag_q);

    // R4
    no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !(tick_en && cnt_nxt == match_q && irqen_q != '0)) |=> !flag_q);

    // R6
    zero_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && wstb.status_we && bus_wdata == '0 && !(tick_en && cnt_nxt == match_q))
        |=> !flag_q);

    // R7
    nonzero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && wstb.status_we && bus_wdata != '0) |=> flag_q);

endmodule

// File: rtl/ost_timer.sv
// Top level of the match-compare system timer.
// Wires the counter, the compare/status unit and the bus decoder together and
// drives the level interrupt from the status flag.
// Assumes: tick_en is already synchronous to clk; synchronous active-low reset.
module ost_timer
    import ost_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [CNT_W-1:0]  match_q;
    logic [DATA_W-1:0] irqen_q;
    logic [DATA_W-1:0] count_val;
    logic              flag_q;
    ost_wstb_t         wstb;

    ost_free_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    ost_match_unit #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .cnt_nxt   (cnt_nxt),
        .wstb      (wstb),
        .bus_wdata (bus_wdata),
        .match_q   (match_q),
        .irqen_q   (irqen_q),
        .flag_q    (flag_q)
    );

    // Counter widened to the bus width for readback
    generate
        if (CNT_W == DATA_W) begin : g_full
            assign count_val = cnt_q;
        end else begin : g_pad
            assign count_val = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
        end
    endgenerate

    ost_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .count_val (count_val),
        .flag_val  (flag_q),
        .irqen_val (irqen_q),
        .wstb      (wstb),
        .bus_rdata (bus_rdata)
    );

    // Level interrupt straight from the sticky flag
    assign irq = flag_q;

    // R3 / R5
    rise_at_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> cnt_q == match_q);

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wstb.status_we && bus_wdata == '0)) |=> irq);

endmodule

// File: tb/tb_ost_timer.sv
module tb_ost_timer;

    localparam int CW   = 10;
    localparam int MASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int unsigned m_cnt = 0, m_match = 0, m_ie = 0;
    bit m_flag = 1'b0;

    always #2 clk = ~clk;

    ost_timer #(.ADDR_W(8), .DATA_W(32), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int unsigned model_read(logic [7:0] a);
        case (a)
            8'h10:   return m_cnt;
            8'h14:   return {31'd0, m_flag};
            8'h1C:   return m_ie;
            default: return 0;
        endcase
    endfunction

    // Reference model: advanced at each edge from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_match <= 0; m_ie <= 0; m_flag <= 1'b0;
        end else begin
            int unsigned nx;
            bit hit, clr;
            nx  = tick_en ? ((m_cnt + 1) & MASK) : m_cnt;
            hit = tick_en && (nx == m_match);
            clr = bus_we && bus_addr == 8'h14 && bus_wdata == 0;
            if (bus_we && bus_addr == 8'h00) m_match <= bus_wdata & MASK;
            if (bus_we && bus_addr == 8'h1C) m_ie <= bus_wdata;
            if (hit && m_ie != 0) m_flag <= 1'b1;
            else if (clr)         m_flag <= 1'b0;
            m_cnt <= nx;
        end
    end

    // Per-cycle comparison, sampled between the edges
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R9 cycle readback", bus_rdata, model_read(bus_addr));
            check("R11 cycle irq", {31'd0, irq}, {31'd0, m_flag});
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // Tick until the counter reads target; irq must stay low before it
    task automatic run_to(string tag, int unsigned target, int maxc,
                          output int cyc, output bit wrapped);
        int unsigned prev;
        cyc = 0; wrapped = 1'b0;
        @(negedge clk);
        bus_addr = 8'h10;
        #1 prev = bus_rdata;
        tick_en = 1'b1;
        while (cyc < maxc) begin
            @(negedge clk);
            cyc++;
            if (bus_rdata < prev) wrapped = 1'b1;
            prev = bus_rdata;
            if (bus_rdata == target) break;
            check(tag, {31'd0, irq}, 32'd0);
        end
        tick_en = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        int cyc;
        bit wrapped;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero after reset
        rd(8'h10, v); check("R1 counter", v, 0);
        rd(8'h14, v); check("R1 status", v, 0);
        rd(8'h1C, v); check("R1 enable", v, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R9: readback of enable, compare and unmapped offsets
        wr(8'h1C, 32'h0000_0001);
        rd(8'h1C, v); check("R9 enable readback", v, 1);
        wr(8'h00, 32'd20);
        rd(8'h00, v); check("R9 compare reads zero", v, 0);
        rd(8'h08, v); check("R9 unmapped reads zero", v, 0);

        // R10: writes to counter and unmapped offsets change nothing
        wr(8'h10, 32'd77);
        wr(8'h08, 32'hDEAD_BEEF);
        wr(8'h15, 32'h0);
        rd(8'h10, v); check("R10 counter untouched", v, 0);
        rd(8'h1C, v); check("R10 enable untouched", v, 1);

        // R2: advance exactly on tick cycles
        @(negedge clk); tick_en = 1'b1;
        repeat (7) @(negedge clk);
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h10, v); check("R2 seven ticks", v, 7);

        // R3: flag rises with the counter reaching 20
        run_to("R3 irq before match", 20, 64, cyc, wrapped);
        check("R3 ticks to match", cyc, 13);
        check("R3 irq at match", {31'd0, irq}, 1);
        rd(8'h14, v); check("R3 status bit", v, 1);

        // R11: disabling does not drop a pending flag
        wr(8'h1C, 32'h0);
        check("R11 irq held", {31'd0, irq}, 1);
        // R7: non-zero status write is ignored
        wr(8'h14, 32'h5);
        rd(8'h14, v); check("R7 status kept", v, 1);
        // R6: zero write clears
        wr(8'h14, 32'h0);
        check("R6 irq cleared", {31'd0, irq}, 0);
        rd(8'h14, v); check("R6 status cleared", v, 0);

        // R4: hit with enable zero leaves flag clear
        wr(8'h00, 32'd25);
        run_to("R4 irq low", 25, 64, cyc, wrapped);
        repeat (2) @(negedge clk);
        check("R4 no irq at match", {31'd0, irq}, 0);

        // R5: compare behind the count waits for the wrap
        wr(8'h1C, 32'h8000_0000);
        wr(8'h00, 32'd10);
        run_to("R5 irq before wrap", 10, 2000, cyc, wrapped);
        check("R5 behind-count distance", cyc, 1009);
        check("R2 wrap seen", {31'd0, wrapped}, 1);
        check("R5 irq after wrap", {31'd0, irq}, 1);
        wr(8'h14, 32'h0);

        // R5: compare equal to the count needs a full lap
        wr(8'h00, 32'd10);
        run_to("R5 irq before full lap", 10, 2000, cyc, wrapped);
        check("R5 equal-count distance", cyc, 1024);
        check("R5 irq after full lap", {31'd0, irq}, 1);

        // R8: hit and zero-write on the same edge, hit wins
        wr(8'h14, 32'h0);
        wr(8'h00, 32'd11);
        @(negedge clk);
        bus_addr = 8'h14; bus_we = 1'b1; bus_wdata = 32'h0; tick_en = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
        check("R8 flag kept", {31'd0, irq}, 1);
        rd(8'h10, v); check("R8 counter at compare", v, 11);
        wr(8'h14, 32'h0);
        check("R6 final clear", {31'd0, irq}, 0);

        // R1: reset mid-run returns everything to zero
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(8'h10, v); check("R1 counter after reset", v, 0);
        rd(8'h1C, v); check("R1 enable after reset", v, 0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule